// File: doc/BRIEF.md
# Paged program counter unit

This block holds the 12-bit fetch address for a small 8-bit microcontroller whose program store is divided into four pages of 1024 words. Each clock it carries out one program-flow action: it advances by one, jumps, calls, takes a byte written straight into the counter, or returns. The two page bits come from the status register as an input, and the block keeps them for none of its own use. They form the top two address bits on every jump, call and direct write. A return restores the whole saved address, so control goes back to the caller's page whatever the page bits hold at that moment.

A call saves the address after the call on an internal return stack of eight entries. When the stack is full or empty the pointer wraps round, and no error is reported. The registered counter drives the fetch address. The instruction decoder owns the request lines. When it raises more than one request in the same cycle, a fixed priority picks the single action that takes effect.

Top module: `paged_pc`

## Requirements
- R1: Synchronous active-low reset sets the fetch address to 0x000 and clears every return-stack entry to 0x000, so a return taken directly after reset yields 0x000.
- R2: With only the advance request active, the address rises by one and wraps from 0xFFF to 0x000.
- R3: A jump loads bits 11:10 from the page input (00 = page 0 at 0x000–0x3FF, 01 = page 1 at 0x400–0x7FF, 10 = page 2 at 0x800–0xBFF, 11 = page 3 at 0xC00–0xFFF) and bits 9:0 from the 10-bit target.
- R4: A call forms the new address in the same way as a jump. It also pushes the current address plus one, taken modulo 4096, onto the return stack.
- R5: A direct write puts the written byte in bits 7:0, clears bits 9:8 and loads bits 11:10 from the page input.
- R6: A return pops all 12 bits from the stack into the address, and the page input has no effect on it.
- R7: The return stack is last-in first-out with 8 entries and a circular pointer. A ninth push without a pop overwrites the oldest entry. A pop from an empty stack reads the slot just below the pointer.
- R8: When several requests arrive in one cycle, only one acts, in the priority return, then call, then jump, then write, then advance.
- R9: With no request active, the address holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Advance by one |
| jump_i | input | 1 | Jump to the target |
| call_i | input | 1 | Call the target and save the next address |
| ret_i | input | 1 | Return to the last saved address |
| wr_i | input | 1 | Direct write of the counter's low byte |
| tgt_i | input | 10 | Target offset within the page for jump and call |
| wdata_i | input | 8 | Byte for a direct write |
| page_i | input | 2 | Page-select bits from the status register |
| pc_o | output | 12 | Fetch address |

## Verification
A call and a return can meet in the same cycle, and so can a jump and a direct write. In each case only the higher-priority action may change the address and the stack. The bench raises all five requests together, then call with jump and advance, then jump with write, then write with advance. It compares the result with a model that applies only the winning action. A following return shows whether a losing call pushed anything by mistake.

// File: rtl/ppc_pkg.sv
// Package: shared types for the paged program counter unit.
// Assumes: one program-flow action per cycle, chosen by a fixed priority.
package ppc_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_STEP  = 3'd1,
        OP_WRITE = 3'd2,
        OP_JUMP  = 3'd3,
        OP_CALL  = 3'd4,
        OP_RET   = 3'd5
    } op_e;

endpackage

// File: rtl/ppc_op_sel.sv
// Module: ppc_op_sel
// Turns the raw request lines into one action by fixed priority:
// return, call, jump, write, advance, otherwise hold.
// Assumes: the request lines are synchronous to clk.
module ppc_op_sel
    import ppc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic jump_i,
    input  logic call_i,
    input  logic ret_i,
    input  logic wr_i,
    output op_e  op_o
);

    // Priority encoder over the five requests.
    always_comb begin
        if (ret_i)       op_o = OP_RET;
        else if (call_i) op_o = OP_CALL;
        else if (jump_i) op_o = OP_JUMP;
        else if (wr_i)   op_o = OP_WRITE;
        else if (step_i) op_o = OP_STEP;
        else             op_o = OP_HOLD;
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !jump_i && !call_i && !ret_i && !wr_i) |-> (op_o == OP_HOLD)) // R9
        else $error("idle requests did not give hold");

endmodule

// File: rtl/ppc_ret_stack.sv
// Module: ppc_ret_stack
// Circular LIFO return-address store. A push writes at the pointer and
// moves it up; a pop moves it down. The top entry is always visible.
// Assumes: DEPTH is a power of two so that the pointer wraps naturally;
// push and pop never arrive together (the selector makes them exclusive).
module ppc_ret_stack #(
    parameter int W     = 12,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic [W-1:0]             din_i,
    output logic [W-1:0]             top_o,
    output logic [$clog2(DEPTH)-1:0] ptr_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] below;

    // Slot just under the pointer: the most recent push.
    assign below = ptr_q - PTR_ONE;
    assign top_o = mem_q[below];
    assign ptr_o = ptr_q;

    // Pointer update, wrapping in both directions.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (push_i) ptr_q <= ptr_q + PTR_ONE;
        else if (pop_i)  ptr_q <= below;
    end

    // Entry storage: cleared on reset, one slot written per push.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[g] <= '0;
                else if (push_i && (ptr_q == PTR_W'(g)))
                    mem_q[g] <= din_i;
            end
        end
    endgenerate

    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)) // R8
        else $error("push and pop together");

    AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_o == $past(din_i))) // R7
        else $error("pushed value not on top");

endmodule

// File: rtl/ppc_next_addr.sv
// Module: ppc_next_addr
// Forms the next fetch address for the chosen action and the return
// address that a call saves.
// Assumes: the page bits sit above a PC_W-PAGE_W bit in-page offset, and the
// direct-write byte fits inside that offset.
module ppc_next_addr
    import ppc_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int PAGE_W = 2,
    parameter int BYTE_W = 8
) (
    input  op_e                   op_i,
    input  logic [PC_W-1:0]       pc_i,
    input  logic [PAGE_W-1:0]     page_i,
    input  logic [PC_W-PAGE_W-1:0] tgt_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    input  logic [PC_W-1:0]       pop_i,
    output logic [PC_W-1:0]       next_o,
    output logic [PC_W-1:0]       link_o
);

    localparam int OFF_W = PC_W - PAGE_W;
    localparam int GAP_W = OFF_W - BYTE_W;
    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    logic [PC_W-1:0] inc;

    // Sequential successor, wrapping at the top of the space.
    assign inc    = pc_i + PC_ONE;
    assign link_o = inc;

    // Next-address multiplexer by action.
    always_comb begin
        unique case (op_i)
            OP_STEP:          next_o = inc;
            OP_WRITE:         next_o = {page_i, {GAP_W{1'b0}}, wdata_i};
            OP_JUMP, OP_CALL: next_o = {page_i, tgt_i};
            OP_RET:           next_o = pop_i;
            default:          next_o = pc_i;
        endcase
    end

endmodule

// File: rtl/paged_pc.sv
// Module: paged_pc (top)
// Program counter with page-select upper bits and a circular return stack.
// Assumes: page_i mirrors the status-register page field and is only
// sampled on jump, call and direct write; returns ignore it.
module paged_pc
    import ppc_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int PAGE_W = 2,
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_i,
    input  logic                    jump_i,
    input  logic                    call_i,
    input  logic                    ret_i,
    input  logic                    wr_i,
    input  logic [PC_W-PAGE_W-1:0]  tgt_i,
    input  logic [BYTE_W-1:0]       wdata_i,
    input  logic [PAGE_W-1:0]       page_i,
    output logic [PC_W-1:0]         pc_o
);

    localparam int OFF_W = PC_W - PAGE_W;
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [PC_W-1:0]  PC_ONE  = PC_W'(1);

    op_e              op;
    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  pc_next;
    logic [PC_W-1:0]  link;
    logic [PC_W-1:0]  stack_top;
    logic [PTR_W-1:0] sp;

    ppc_op_sel u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .jump_i (jump_i),
        .call_i (call_i),
        .ret_i  (ret_i),
        .wr_i   (wr_i),
        .op_o   (op)
    );

    ppc_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (op == OP_CALL),
        .pop_i  (op == OP_RET),
        .din_i  (link),
        .top_o  (stack_top),
        .ptr_o  (sp)
    );

    ppc_next_addr #(.PC_W(PC_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_next (
        .op_i    (op),
        .pc_i    (pc_q),
        .page_i  (page_i),
        .tgt_i   (tgt_i),
        .wdata_i (wdata_i),
        .pop_i   (stack_top),
        .next_o  (pc_next),
        .link_o  (link)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_o = pc_q;

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=> (pc_q == $past(pc_q) + PC_ONE)) // R2
        else $error("advance did not add one");

    AST_JUMP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JUMP) |=> (pc_q == {$past(page_i), $past(tgt_i)})) // R3
        else $error("jump address wrong");

    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL) |=> ((sp == $past(sp) + PTR_ONE) &&
                             (pc_q[PC_W-1:OFF_W] == $past(page_i)))) // R4
        else $error("call did not push or page wrong");

    AST_WRITE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> ((pc_q[BYTE_W-1:0] == $past(wdata_i)) &&
                              (pc_q[OFF_W-1:BYTE_W] == '0) &&
                              (pc_q[PC_W-1:OFF_W] == $past(page_i)))) // R5
        else $error("direct write fields wrong");

    AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RET) |=> ((sp == $past(sp) - PTR_ONE) &&
                            (pc_q == $past(stack_top)))) // R6
        else $error("return did not pop");

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(pc_q)) // R9
        else $error("address moved while idle");

endmodule

// File: tb/paged_pc_tb_top.sv
// Scoreboard bench: the driver applies one cycle of requests, updates a
// behavioural model and queues the expected address; the monitor pops and
// compares at the following falling edge.
module paged_pc_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_i = 1'b0, jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, wr_i = 1'b0;
    logic [9:0] tgt_i = '0;
    logic [7:0] wdata_i = '0;
    logic [1:0] page_i = '0;
    logic [11:0] pc_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [11:0] exp_q [$];
    string       tag_q [$];

    logic [11:0] m_pc = '0;
    logic [11:0] m_stk [8];
    logic [2:0]  m_sp = '0;

    always #5 clk = ~clk;

    paged_pc dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
        .call_i(call_i), .ret_i(ret_i), .wr_i(wr_i), .tgt_i(tgt_i),
        .wdata_i(wdata_i), .page_i(page_i), .pc_o(pc_o)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    // Monitor: compare queued expectations with the registered address.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [11:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, pc_o, e);
        end
    end

    // Driver: one cycle of requests, model update by priority, queue result.
    task automatic drive(input string tag, input bit r, input bit c, input bit j,
                         input bit w, input bit s, input logic [1:0] pg,
                         input logic [9:0] tg, input logic [7:0] wd);
        @(negedge clk);
        ret_i = r; call_i = c; jump_i = j; wr_i = w; step_i = s;
        page_i = pg; tgt_i = tg; wdata_i = wd;
        if (r) begin
            m_sp = m_sp - 3'd1;
            m_pc = m_stk[m_sp];
        end else if (c) begin
            m_stk[m_sp] = m_pc + 12'd1;
            m_sp = m_sp + 3'd1;
            m_pc = {pg, tg};
        end else if (j) begin
            m_pc = {pg, tg};
        end else if (w) begin
            m_pc = {pg, 2'b00, wd};
        end else if (s) begin
            m_pc = m_pc + 12'd1;
        end
        @(posedge clk);
        #1;
        ret_i = 0; call_i = 0; jump_i = 0; wr_i = 0; step_i = 0;
        exp_q.push_back(m_pc);
        tag_q.push_back(tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset address", pc_o, 12'h000);

        drive("R2 advance", 0,0,0,0,1, 2'd0, 10'h0, 8'h0);
        drive("R2 advance", 0,0,0,0,1, 2'd0, 10'h0, 8'h0);
        drive("R2 advance", 0,0,0,0,1, 2'd0, 10'h0, 8'h0);
        drive("R9 idle hold", 0,0,0,0,0, 2'd3, 10'h3AA, 8'h55);
        drive("R9 idle hold", 0,0,0,0,0, 2'd1, 10'h001, 8'hFF);
        drive("R3 jump page1", 0,0,1,0,0, 2'd1, 10'h155, 8'h0);
        drive("R5 direct write page2", 0,0,0,1,0, 2'd2, 10'h3FF, 8'hA7);
        drive("R4 call page3", 0,1,0,0,0, 2'd3, 10'h010, 8'h0);
        drive("R2 advance in callee", 0,0,0,0,1, 2'd0, 10'h0, 8'h0);
        drive("R6 return ignores page", 1,0,0,0,0, 2'd0, 10'h0, 8'h0);
        drive("R1 empty-stack return gives cleared entry", 1,0,0,0,0, 2'd1, 10'h0, 8'h0);
        drive("R3 jump page3 end", 0,0,1,0,0, 2'd3, 10'h3FF, 8'h0);
        drive("R2 wrap FFF to 000", 0,0,0,0,1, 2'd0, 10'h0, 8'h0);
        drive("R3 jump to FFF", 0,0,1,0,0, 2'd3, 10'h3FF, 8'h0);
        drive("R4 call at FFF saves 000", 0,1,0,0,0, 2'd2, 10'h123, 8'h0);
        drive("R6 return to 000", 1,0,0,0,0, 2'd3, 10'h0, 8'h0);

        for (int k = 0; k < 9; k++)
            drive("R7 nested call", 0,1,0,0,0, 2'(k), 10'(16*k + 3), 8'h0);
        for (int k = 0; k < 9; k++)
            drive("R7 unwind with wrap", 1,0,0,0,0, 2'(3 - (k % 4)), 10'h0, 8'h0);

        drive("R3 jump setup", 0,0,1,0,0, 2'd1, 10'h020, 8'h0);
        drive("R4 call setup", 0,1,0,0,0, 2'd2, 10'h040, 8'h0);
        drive("R8 all requests: return wins", 1,1,1,1,1, 2'd3, 10'h3C3, 8'h3C);
        drive("R8 call over jump and advance", 0,1,1,0,1, 2'd1, 10'h2AA, 8'h11);
        drive("R8 jump over write", 0,0,1,1,0, 2'd2, 10'h0F0, 8'hEE);
        drive("R8 write over advance", 0,0,0,1,1, 2'd3, 10'h0, 8'h5A);
        drive("R8 losing call did not push", 1,0,0,0,0, 2'd0, 10'h0, 8'h0);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule